// File: doc/BRIEF.md
# Shared-Bus I2C Condition and Arbitration Watcher

This block observes the two wires of an I2C bus on which more than one master may drive. It passes both lines through a synchroniser, recognises START and STOP conditions, and keeps two sticky flags: one for the most recent START and one for the most recent STOP. From these flags it derives a bus-free indication. The local master may claim the bus only when that indication is high.

When the bus is busy and a STOP is seen, the block can raise a one-cycle interrupt. This lets a master that is waiting for the bus resume.

While the local master engine drives the bus, the block compares the level it sees on SDA with the level the master intended. If the master releases SDA to signal a one and the line reads low while SCL is high, another master has won the bus. In that case the block sets a sticky collision flag and emits a one-cycle arbitration-lost strobe. The strobe tells the engine to release both lines at once. The compare runs only in the phases where arbitration can be lost.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, `start_seen`, `stop_seen`, `irq`, `bus_coll` and `arb_lost` are 0 and `bus_free` is 1.
- R2: SDA falling while SCL is high (a START) sets `start_seen` and clears `stop_seen`. The flag updates three clock edges after the raw input changes.
- R3: SDA rising while SCL is high (a STOP) sets `stop_seen` and clears `start_seen`.
- R4: An SDA change while SCL is low changes neither flag.
- R5: `bus_free` is 1 when `stop_seen` is 1, or when both flags are 0. It is 0 otherwise.
- R6: A STOP seen while `bus_free` is 0, with `irq_en` and `enable` high, gives exactly one cycle of `irq`. A STOP seen while the bus is already free, or with `irq_en` low, gives none.
- R7: While `enable` is 0, both flags are held at 0, conditions on the bus are ignored, and no collision is detected.
- R8: Phase codes are 0 idle, 1 start, 2 repeated start, 3 address, 4 data, 5 acknowledge, 6 stop and 7 receive. In phases 1 to 5, if `drive_active` is 1, `sda_drive` is 1, synchronised SCL is 1 and synchronised SDA is 0, then `bus_coll` is set.
- R9: No collision is flagged in phases 0, 6 or 7. None is flagged when `drive_active` is 0, when `sda_drive` is 0, or when SCL is low.
- R10: `bus_coll` stays set until `clr_coll` is pulsed. If a new mismatch arrives in the same cycle as the clear, the set takes priority.
- R11: `arb_lost` is a single-cycle pulse. It is issued only when a mismatch arrives while `bus_coll` is clear, so a persisting mismatch gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears the condition flags |
| irq_en | input | 1 | Enable for the STOP interrupt |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| sda_drive | input | 1 | SDA level the local master intends (1 = released) |
| drive_active | input | 1 | Local master is currently driving the bus |
| phase | input | 3 | Current master phase code (see R8) |
| clr_coll | input | 1 | Clears the collision flag |
| start_seen | output | 1 | Sticky START-seen flag |
| stop_seen | output | 1 | Sticky STOP-seen flag |
| bus_free | output | 1 | Bus may be claimed |
| irq | output | 1 | One-cycle STOP interrupt |
| bus_coll | output | 1 | Sticky bus-collision flag |
| arb_lost | output | 1 | One-cycle arbitration-lost strobe |

## Verification
The assertions assume that `phase`, `sda_drive` and `drive_active` are synchronous to `clk`. They also assume that `clr_coll` is a deliberate software pulse, not a level that is left high. The stimulus changes every input on the falling clock edge. It holds each setting for several cycles so that the synchroniser settles, and it never changes SDA and SCL in the same cycle. During the collision sweep, SCL is brought low before SDA and the phase inputs are altered, so the sweep itself never creates a spurious START or STOP.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_RSTART = 3'd2,
    PH_ADDR   = 3'd3,
    PH_DATA   = 3'd4,
    PH_ACK    = 3'd5,
    PH_STOP   = 3'd6,
    PH_RECV   = 3'd7
  } master_phase_e;

  // Phases where another master can take the bus from us
  function automatic logic phase_can_lose(input logic [2:0] ph);
    return (ph >= 3'd1) && (ph <= 3'd5);
  endfunction

  function automatic logic free_from_flags(input logic st, input logic sp);
    return sp | ~st;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  localparam int LAST = STAGES - 1;

  for (genvar w = 0; w < WIDTH; w++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[w]};
    end
    assign d_out[w] = chain[LAST];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_ev,
  output logic stop_ev
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  assign start_ev = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check
  import i2c_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sda_s,
  input  logic       scl_s,
  input  logic       sda_drive,
  input  logic       drive_active,
  input  logic [2:0] phase,
  input  logic       clr_coll,
  output logic       mismatch,
  output logic       bus_coll,
  output logic       arb_lost
);
  assign mismatch = enable & drive_active & phase_can_lose(phase)
                  & sda_drive & scl_s & ~sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_coll <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      arb_lost <= mismatch & ~bus_coll;
      if (mismatch)      bus_coll <= 1'b1;
      else if (clr_coll) bus_coll <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       irq_en,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       sda_drive,
  input  logic       drive_active,
  input  logic [2:0] phase,
  input  logic       clr_coll,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       bus_free,
  output logic       irq,
  output logic       bus_coll,
  output logic       arb_lost
);
  logic sda_s, scl_s;
  logic start_ev, stop_ev, mismatch;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out ({scl_s, sda_s})
  );

  i2c_cond_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_arb_check u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sda_s        (sda_s),
    .scl_s        (scl_s),
    .sda_drive    (sda_drive),
    .drive_active (drive_active),
    .phase        (phase),
    .clr_coll     (clr_coll),
    .mismatch     (mismatch),
    .bus_coll     (bus_coll),
    .arb_lost     (arb_lost)
  );

  assign bus_free = free_from_flags(start_seen, stop_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      irq        <= 1'b0;
    end else if (!enable) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= stop_ev & irq_en & ~bus_free;
      if (start_ev) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
      end else if (stop_ev) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic clr_coll,
  input logic start_ev,
  input logic stop_ev,
  input logic mismatch,
  input logic start_seen,
  input logic stop_seen,
  input logic bus_free,
  input logic irq,
  input logic bus_coll,
  input logic arb_lost
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen)); // R2
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_ev) |=> start_seen); // R2
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_ev && !start_ev) |=> stop_seen); // R3
  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen)); // R7
  AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stop_seen && !$past(bus_free))); // R6
  AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> bus_coll); // R8
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_coll && !clr_coll) |=> bus_coll); // R10
  AST_ARB_WITH_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> bus_coll); // R11
  AST_ARB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost); // R11
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .clr_coll   (clr_coll),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .mismatch   (mismatch),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .bus_free   (bus_free),
  .irq        (irq),
  .bus_coll   (bus_coll),
  .arb_lost   (arb_lost)
);

// File: tb/tb_i2c_bus_watch.sv
module tb_i2c_bus_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, irq_en = 1'b0, sda_in = 1'b1, scl_in = 1'b1;
  logic sda_drive = 1'b1, drive_active = 1'b0, clr_coll = 1'b0;
  logic [2:0] phase = 3'd0;
  logic start_seen, stop_seen, bus_free, irq, bus_coll, arb_lost;

  int checks = 0, fails = 0;
  int irq_cnt = 0, arb_cnt = 0;
  logic m_st = 1'b0, m_sp = 1'b0;

  always #10 clk = ~clk;

  i2c_bus_watch dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
    .sda_in(sda_in), .scl_in(scl_in), .sda_drive(sda_drive),
    .drive_active(drive_active), .phase(phase), .clr_coll(clr_coll),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .irq(irq), .bus_coll(bus_coll), .arb_lost(arb_lost)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (arb_lost) arb_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    check({req, " start_seen"}, start_seen, m_st);
    check({req, " stop_seen"}, stop_seen, m_sp);
    check({req, " bus_free"}, bus_free, (m_sp || !m_st) ? 1 : 0);
  endtask

  task automatic do_start();
    scl_in = 1'b0; settle(); sda_in = 1'b1; settle();
    scl_in = 1'b1; settle(); sda_in = 1'b0; settle();
    if (enable) begin m_st = 1'b1; m_sp = 1'b0; end
  endtask

  task automatic do_stop();
    scl_in = 1'b0; settle(); sda_in = 1'b0; settle();
    scl_in = 1'b1; settle(); sda_in = 1'b1; settle();
    if (enable) begin m_st = 1'b0; m_sp = 1'b1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 start_seen", start_seen, 0);
    check("R1 stop_seen", stop_seen, 0);
    check("R1 bus_free", bus_free, 1);
    check("R1 irq", irq, 0);
    check("R1 bus_coll", bus_coll, 0);
    check("R1 arb_lost", arb_lost, 0);
    rst_n = 1'b1; enable = 1'b1; irq_en = 1'b1;
    settle();

    // R2, R5: START makes bus busy
    irq_cnt = 0;
    do_start(); check_flags("R2");
    check("R5 busy after start", bus_free, 0);
    // R4: SDA toggles with SCL low leave flags alone
    scl_in = 1'b0; settle();
    for (int k = 0; k < 4; k++) begin
      sda_in = ~sda_in; settle();
      check_flags("R4");
    end
    // R3, R6: STOP while busy -> one interrupt
    do_stop(); check_flags("R3");
    check("R6 irq once on busy stop", irq_cnt, 1);
    // R6: STOP while already free -> no interrupt
    irq_cnt = 0;
    do_stop(); check_flags("R3 repeat");
    check("R6 no irq when free", irq_cnt, 0);
    // R6: irq disabled
    irq_en = 1'b0;
    do_start(); do_stop();
    check("R6 no irq when irq_en low", irq_cnt, 0);
    irq_en = 1'b1;
    do_start();
    // R7: disable clears and ignores
    enable = 1'b0; settle();
    m_st = 1'b0; m_sp = 1'b0;
    check_flags("R7 cleared");
    do_start(); check_flags("R7 start ignored");
    do_stop(); check_flags("R7 stop ignored");
    check("R7 no irq", irq_cnt, 0);
    sda_drive = 1'b1; drive_active = 1'b1; phase = 3'd3;
    scl_in = 1'b0; settle(); sda_in = 1'b0; settle(); scl_in = 1'b1; settle();
    check("R7 no collision when disabled", bus_coll, 0);
    drive_active = 1'b0; scl_in = 1'b0; settle(); sda_in = 1'b1; settle();
    enable = 1'b1; settle();

    // R8, R9, R11: exhaustive collision sweep
    for (int c = 0; c < 64; c++) begin
      logic [2:0] ph;
      logic da, sd, sc, sa, exp;
      ph = c[5:3]; da = c[2]; sd = c[1]; sc = c[0];
      for (int s = 0; s < 2; s++) begin
        sa = s[0];
        scl_in = 1'b0; drive_active = 1'b0; settle();
        clr_coll = 1'b1; @(negedge clk); clr_coll = 1'b0; settle();
        arb_cnt = 0;
        phase = ph; drive_active = da; sda_drive = sd;
        sda_in = sa; settle();
        scl_in = sc; repeat (6) @(negedge clk);
        exp = (ph >= 3'd1 && ph <= 3'd5) && da && sd && sc && !sa;
        check(exp ? "R8 coll set" : "R9 no coll", bus_coll, exp);
        check("R11 single arb pulse", arb_cnt, exp);
      end
    end

    // R10: sticky, then clear, then set beats clear
    scl_in = 1'b0; drive_active = 1'b0; settle();
    clr_coll = 1'b1; @(negedge clk); clr_coll = 1'b0;
    phase = 3'd4; sda_drive = 1'b1; drive_active = 1'b1; sda_in = 1'b0; settle();
    scl_in = 1'b1; settle();
    scl_in = 1'b0; drive_active = 1'b0; repeat (8) @(negedge clk);
    check("R10 sticky", bus_coll, 1);
    clr_coll = 1'b1; @(negedge clk); clr_coll = 1'b0; @(negedge clk);
    check("R10 cleared", bus_coll, 0);
    drive_active = 1'b1; scl_in = 1'b1; settle();
    clr_coll = 1'b1; @(negedge clk); clr_coll = 1'b0; @(negedge clk);
    check("R10 set beats clear", bus_coll, 1);
    drive_active = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule